// File: doc/BRIEF.md
# Clocked Synchronous Byte Serial Port

This block moves one byte at a time over a three-wire synchronous serial link while acting as the clock master. A host reaches it through a small register interface. The host places a byte in the transmit data register and then writes 0 to the transmit-empty status bit. That write starts a transfer. The byte is copied into the transmit shift register and the empty flag returns to 1 at once, so the host can queue the next byte while the current one is still on the wire.

Every transfer clocks eight bits out on the data-out pin and eight bits in from the data-in pin. It uses eight pulses of a serial clock that idles high. Between bytes the data-out pin keeps its last bit. When a byte has been received it goes to the receive data register and the receive-full flag is raised. A byte that completes while that flag is still set is dropped and the overrun flag is raised. Transmission carries on regardless. Three interrupt request lines (transmit, receive, receive error) are level outputs derived from the flags and their enable bits.

Top module: `sync_serial_port`

## Requirements
- R1: Register map on `hostAddr`: 0 = transmit data (read/write), 1 = receive data (read only; writes are ignored), 2 = status, 3 = control. Status bits: bit7 transmit-empty, bit6 receive-full, bit5 overrun, bit4 framing error, bit3 parity error; bits 2..0 read 0. Control bits: bit0 transmit interrupt enable, bit1 receive interrupt enable; the other bits read 0. After reset, status reads 0x80, control and both data registers read 0x00, `sclk` is 1 and `txd` is 1.
- R2: Writing status with bit7 = 0 while transmit-empty is 1 starts a transfer. One clock later the transmit data register has been copied into the shift register, transmit-empty reads 1 and `sclk` is low. Writing bit7 = 1 has no effect.
- R3: A transfer produces exactly eight `sclk` low/high pulses, each half lasting `HALF_CYCLES` clocks, and `sclk` idles high. `txd` changes on falling `sclk`, least significant bit first. `rxd` is sampled at rising `sclk`, with the first sampled bit going to the least significant position.
- R4: After a transfer, with no new start, `txd` holds the last (most significant) bit of the byte sent and `sclk` stays high.
- R5: On the eighth rising `sclk`, if receive-full is 0, the received byte is written to the receive data register and receive-full is set.
- R6: If receive-full is 1 on the eighth rising `sclk`, overrun is set, the receive data register keeps its earlier byte and the new byte is discarded. The byte being transmitted still goes out complete. Overrun is cleared only when the host writes status with bit5 = 0.
- R7: Receive-full is cleared by writing status with bit6 = 0. Writing bit6 = 1 leaves it unchanged.
- R8: `txIrq` = transmit-empty AND transmit enable; `rxIrq` = receive-full AND receive enable; `errIrq` = (overrun OR framing OR parity) AND receive enable.
- R9: The framing and parity bits take the value written to status bits 4 and 3 and are otherwise never changed by the block.
- R10: If transmit-empty has been cleared again before the current byte ends, the next byte starts right after the eighth high phase with no idle gap. Consecutive byte completions are then 16*`HALF_CYCLES` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Register write strobe |
| hostAddr | input | 2 | Register select |
| hostWrData | input | 8 | Register write data |
| hostRdData | output | 8 | Register read data, combinational on `hostAddr` |
| sclk | output | 1 | Serial clock, idles high |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Receive error interrupt request |

## Verification
The hardest case to reach is back-to-back transmission. The host must write the second byte and clear transmit-empty again while the first byte is still shifting. The received byte must also be cleared within one byte time, or the second byte overruns. The bench queues the second start a few clocks after the first, clears receive-full as soon as the first byte lands, and time-stamps both completions so that any idle gap shows up. An overrun is provoked by deliberately leaving receive-full set across a second transfer.

// File: rtl/sync_serial_pkg.sv
package sync_serial_pkg;

  localparam int BYTE_BITS = 8;

  // status register bit positions
  localparam int ST_TXE = 7;
  localparam int ST_RXF = 6;
  localparam int ST_OVR = 5;
  localparam int ST_FER = 4;
  localparam int ST_PER = 3;

  // control register bit positions
  localparam int CT_TIE = 0;
  localparam int CT_RIE = 1;

  // register addresses
  localparam logic [1:0] A_TDATA  = 2'd0;
  localparam logic [1:0] A_RDATA  = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;
  localparam logic [1:0] A_CTRL   = 2'd3;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;    // copy transmit data into shift register, drive bit 0
    logic shift;   // falling edge inside a byte: drive next bit
    logic sample;  // rising edge: capture rxd
    logic finish;  // eighth rising edge: commit received byte
  } seq_strobe_t;

endpackage

// File: rtl/ssp_sequencer.sv
module ssp_sequencer
  import sync_serial_pkg::*;
#(
  parameter int HALF_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  output seq_strobe_t strobe,
  output logic        sclkOut
);

  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int BIT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYCLES - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(BYTE_BITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} state_t;

  state_t           state;
  logic [CNT_W-1:0] halfCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             lastHalf;
  logic             lastBit;

  assign lastHalf = (halfCnt == HALF_LAST);
  assign lastBit  = (bitCnt == BIT_LAST);

  always_comb begin
    strobe = '0;
    case (state)
      S_IDLE: strobe.load = startReq;
      S_LOW: begin
        if (lastHalf) begin
          strobe.sample = 1'b1;
          strobe.finish = lastBit;
        end
      end
      S_HIGH: begin
        if (lastHalf) begin
          if (!lastBit) strobe.shift = 1'b1;
          else          strobe.load  = startReq;
        end
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
      sclkOut <= 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          if (startReq) begin
            state   <= S_LOW;
            sclkOut <= 1'b0;
            halfCnt <= '0;
            bitCnt  <= '0;
          end
        end
        S_LOW: begin
          if (lastHalf) begin
            state   <= S_HIGH;
            sclkOut <= 1'b1;
            halfCnt <= '0;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (lastHalf) begin
            halfCnt <= '0;
            if (!lastBit) begin
              bitCnt  <= bitCnt + 1'b1;
              sclkOut <= 1'b0;
              state   <= S_LOW;
            end else if (startReq) begin
              bitCnt  <= '0;
              sclkOut <= 1'b0;
              state   <= S_LOW;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> sclkOut);

  // R3
  sample_rises_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample |=> sclkOut);

  // R3
  drive_falls_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load || strobe.shift) |=> !sclkOut);

endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import sync_serial_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostAddr,
  input  logic [7:0]  hostWrData,
  output logic [7:0]  hostRdData,
  input  seq_strobe_t strobe,
  input  logic        rxd,
  output logic        txd,
  output logic        txEmpty,
  output logic        txIrq,
  output logic        rxIrq,
  output logic        errIrq
);

  logic [BYTE_BITS-1:0] txData, txShift, rxShift, rxData;
  logic rxFull, overrun, frameErr, parityErr, txIe, rxIe;
  logic [BYTE_BITS-1:0] rxNext;

  assign rxNext = {rxd, rxShift[BYTE_BITS-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData    <= '0;
      txShift   <= '0;
      rxShift   <= '0;
      rxData    <= '0;
      txd       <= 1'b1;
      txEmpty   <= 1'b1;
      rxFull    <= 1'b0;
      overrun   <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
      txIe      <= 1'b0;
      rxIe      <= 1'b0;
    end else begin
      if (hostWrEn) begin
        case (hostAddr)
          A_TDATA: txData <= hostWrData;
          A_STATUS: begin
            if (!hostWrData[ST_TXE]) txEmpty <= 1'b0;
            if (!hostWrData[ST_RXF]) rxFull  <= 1'b0;
            if (!hostWrData[ST_OVR]) overrun <= 1'b0;
            frameErr  <= hostWrData[ST_FER];
            parityErr <= hostWrData[ST_PER];
          end
          A_CTRL: begin
            txIe <= hostWrData[CT_TIE];
            rxIe <= hostWrData[CT_RIE];
          end
          default: ;
        endcase
      end
      if (strobe.load) begin
        txShift <= txData;
        txd     <= txData[0];
        txEmpty <= 1'b1;
      end
      if (strobe.shift) begin
        txd     <= txShift[1];
        txShift <= txShift >> 1;
      end
      if (strobe.sample) rxShift <= rxNext;
      if (strobe.finish) begin
        if (rxFull) begin
          overrun <= 1'b1;
        end else begin
          rxData <= rxNext;
          rxFull <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (hostAddr)
      A_TDATA:  hostRdData = txData;
      A_RDATA:  hostRdData = rxData;
      A_STATUS: hostRdData = {txEmpty, rxFull, overrun, frameErr, parityErr, 3'b000};
      default:  hostRdData = {6'b0, rxIe, txIe};
    endcase
  end

  assign txIrq  = txEmpty & txIe;
  assign rxIrq  = rxFull & rxIe;
  assign errIrq = (overrun | frameErr | parityErr) & rxIe;

  // R2
  load_sets_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> txEmpty);

  // R4
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.shift) |=> $stable(txd));

  // R5
  rx_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !rxFull) |=> rxFull);

  // R6
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && rxFull) |=> (overrun && $stable(rxData)));

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import sync_serial_pkg::*;
#(
  parameter int HALF_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWrEn,
  input  logic [1:0] hostAddr,
  input  logic [7:0] hostWrData,
  output logic [7:0] hostRdData,
  output logic       sclk,
  output logic       txd,
  input  logic       rxd,
  output logic       txIrq,
  output logic       rxIrq,
  output logic       errIrq
);

  seq_strobe_t strobe;
  logic        txEmpty;

  ssp_sequencer #(.HALF_CYCLES(HALF_CYCLES)) i_seq (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (!txEmpty),
    .strobe   (strobe),
    .sclkOut  (sclk)
  );

  ssp_datapath i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrEn   (hostWrEn),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .strobe     (strobe),
    .rxd        (rxd),
    .txd        (txd),
    .txEmpty    (txEmpty),
    .txIrq      (txIrq),
    .rxIrq      (rxIrq),
    .errIrq     (errIrq)
  );

endmodule

// File: tb/test_sync_serial_port.sv
`timescale 1ns/1ps
module test_sync_serial_port;

  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [7:0] hostWrData = 8'h00;
  logic [7:0] hostRdData;
  logic       sclk, txd, txIrq, rxIrq, errIrq;
  logic       rxd = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // serial slave model
  int       sBit = 0;
  int       slaveBytes = 0;
  int       sclkRises = 0;
  logic [7:0] slaveTx = 8'h00, slaveNext = 8'h00, slaveGot = 8'h00, lastGot = 8'h00;
  realtime  doneTime [0:63];

  sync_serial_port #(.HALF_CYCLES(HALF)) i_sync_serial_port (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .sclk(sclk), .txd(txd),
    .rxd(rxd), .txIrq(txIrq), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  always #10 clk = ~clk;

  always @(negedge sclk) if (rstN) rxd <= slaveTx[sBit];

  always @(posedge sclk) begin
    if (rstN) begin
      sclkRises++;
      slaveGot[sBit] = txd;
      sBit++;
      if (sBit == 8) begin
        sBit = 0;
        lastGot = slaveGot;
        slaveTx = slaveNext;
        if (slaveBytes < 64) doneTime[slaveBytes] = $realtime;
        slaveBytes++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitBytes(input int n);
    for (int i = 0; i < 4000 && slaveBytes < n; i++) @(negedge clk);
    idle(2);
  endtask

  // clear transmit-empty only; 1s on rx-full/overrun leave them unchanged
  task automatic startXfer();
    hostWrite(2'd2, 8'h60);
  endtask

  task automatic testReset();
    logic [7:0] d;
    hostRead(2'd2, d); check(d == 8'h80, "R1 reset status", d, 8'h80);
    hostRead(2'd3, d); check(d == 8'h00, "R1 reset control", d, 8'h00);
    hostRead(2'd1, d); check(d == 8'h00, "R1 reset rx data", d, 8'h00);
    check(sclk === 1'b1 && txd === 1'b1, "R1 reset pins", {sclk, txd}, 2'b11);
    check({txIrq, rxIrq, errIrq} === 3'b000, "R8 reset irqs", {txIrq, rxIrq, errIrq}, 0);
  endtask

  task automatic testSingle();
    logic [7:0] d;
    int r0;
    hostWrite(2'd3, 8'h01);
    check(txIrq === 1'b1, "R8 txIrq with enable", txIrq, 1);
    hostWrite(2'd0, 8'h35);
    hostRead(2'd0, d); check(d == 8'h35, "R1 tx data readback", d, 8'h35);
    slaveTx = 8'h5A; slaveNext = 8'h00;
    r0 = sclkRises;
    startXfer();
    @(negedge clk);
    hostRead(2'd2, d);
    check(d[7] == 1'b1 && sclk == 1'b0, "R2 start sets empty, sclk low", {d[7], sclk}, 2'b10);
    waitBytes(1);
    idle(2 * HALF);
    check(lastGot == 8'h35, "R3 bits sent LSB first", lastGot, 8'h35);
    check(sclkRises - r0 == 8, "R3 eight clock pulses", sclkRises - r0, 8);
    hostRead(2'd1, d); check(d == 8'h5A, "R5 received byte", d, 8'h5A);
    hostRead(2'd2, d); check(d[6] == 1'b1, "R5 receive-full set", d[6], 1);
    idle(40);
    check(txd === 1'b0 && sclk === 1'b1, "R4 txd holds last bit, sclk high", {txd, sclk}, 2'b01);
    check(sclkRises - r0 == 8, "R4 no further pulses", sclkRises - r0, 8);
  endtask

  task automatic testRxClear();
    logic [7:0] d;
    int r0;
    hostWrite(2'd3, 8'h02);
    check(rxIrq === 1'b1 && txIrq === 1'b0, "R8 rxIrq on, txIrq gated", {rxIrq, txIrq}, 2'b10);
    r0 = sclkRises;
    hostWrite(2'd2, 8'hA0);
    hostRead(2'd2, d);
    check(d == 8'h80, "R7 receive-full cleared", d, 8'h80);
    check(rxIrq === 1'b0, "R8 rxIrq drops", rxIrq, 0);
    idle(20);
    check(sclkRises == r0, "R2 writing 1 to empty starts nothing", sclkRises - r0, 0);
  endtask

  task automatic testOverrun();
    logic [7:0] d;
    hostWrite(2'd0, 8'hC3);
    slaveTx = 8'h11; slaveNext = 8'h99;
    startXfer();
    waitBytes(2);
    hostRead(2'd1, d); check(d == 8'h11, "R5 first byte", d, 8'h11);
    hostWrite(2'd0, 8'h7E);
    startXfer();
    waitBytes(3);
    hostRead(2'd2, d); check(d == 8'hE0, "R6 overrun set, full kept", d, 8'hE0);
    hostRead(2'd1, d); check(d == 8'h11, "R6 earlier byte kept", d, 8'h11);
    check(lastGot == 8'h7E, "R6 transmit unaffected", lastGot, 8'h7E);
    check(errIrq === 1'b1, "R8 errIrq on overrun", errIrq, 1);
    hostWrite(2'd2, 8'hC0);
    hostRead(2'd2, d); check(d == 8'hC0, "R6 overrun cleared by 0", d, 8'hC0);
    check(errIrq === 1'b0, "R8 errIrq drops", errIrq, 0);
    hostWrite(2'd2, 8'hA0);
  endtask

  task automatic testBackToBack();
    logic [7:0] d;
    int b0, r0;
    b0 = slaveBytes; r0 = sclkRises;
    hostWrite(2'd0, 8'h81);
    slaveTx = 8'h3C; slaveNext = 8'hE7;
    startXfer();
    hostWrite(2'd0, 8'h42);
    startXfer();
    waitBytes(b0 + 1);
    hostRead(2'd1, d); check(d == 8'h3C, "R10 first byte received", d, 8'h3C);
    hostWrite(2'd2, 8'hA0);
    waitBytes(b0 + 2);
    idle(2 * HALF);
    check(lastGot == 8'h42, "R10 second byte sent", lastGot, 8'h42);
    check(sclkRises - r0 == 16, "R10 sixteen pulses", sclkRises - r0, 16);
    check(doneTime[b0 + 1] - doneTime[b0] == 16.0 * HALF * 20.0, "R10 no idle gap",
          int'(doneTime[b0 + 1] - doneTime[b0]), 16 * HALF * 20);
    hostRead(2'd1, d); check(d == 8'hE7, "R10 second byte received", d, 8'hE7);
    hostRead(2'd2, d); check(d == 8'hC0, "R10 no overrun", d, 8'hC0);
    hostWrite(2'd2, 8'hA0);
  endtask

  task automatic testErrFlags();
    logic [7:0] d;
    hostWrite(2'd2, 8'h98);
    hostRead(2'd2, d); check(d == 8'h98, "R9 framing/parity writable", d, 8'h98);
    check(errIrq === 1'b1, "R8 errIrq from framing/parity", errIrq, 1);
    hostWrite(2'd3, 8'h00);
    check(errIrq === 1'b0, "R8 errIrq gated by enable", errIrq, 0);
    hostWrite(2'd1, 8'h55);
    hostRead(2'd1, d); check(d == 8'hE7, "R1 rx data ignores writes", d, 8'hE7);
    hostWrite(2'd2, 8'h80);
    hostRead(2'd2, d); check(d == 8'h80, "R9 flags cleared by write", d, 8'h80);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    testReset();
    testSingle();
    testRxClear();
    testOverrun();
    testBackToBack();
    testErrFlags();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule